// File: doc/BRIEF.md
# Clock Output Power-Management Controller

This block is the control section of a clock buffer with eight differential output pairs and one single-ended reference output. It runs in the output clock domain. A free-running phase register stands in for the synthesized output clock, and the block decides, pair by pair, whether that clock reaches the pins or is held low. The decision takes in a power-good input, which also acts as the power-down input, the PLL lock flag, one active-low enable pin per pair and one enable bit per pair held in a local register. All of these are synchronized first.

On the first rising of power-good the block captures two configuration straps and keeps them until reset: a bus-address select and a three-level spread select. It presents them decoded as a 7-bit bus address and a spread code. The reference output is undriven until that first power-good. After it, the reference output runs while power-good is high and is driven low during any power-down. An enable change for a pair takes effect only on a cycle boundary where the pair's true line is low. A pair therefore always starts with a full low phase and stops after a full high phase.

Top module: `clkout_pm_ctrl`

## Requirements
- R1: On the first cycle where the synchronized power-good is high, `straps_valid_o` goes to 1 and `smb_addr_o` takes the strap value: 7'b1101000 when `sadr_strap_i` is 0 and 7'b1101010 when it is 1.
- R2: In the same capture, `ss_sel_o` is set from `ss_strap_i`: 2'b00 (low) gives code 0 (no spread), 2'b01 (mid) gives code 1 (-0.25%), and 2'b10 or 2'b11 (high) give code 2 (-0.5%).
- R3: Once captured, `smb_addr_o` and `ss_sel_o` ignore any later change on the strap inputs, including across later power-down and power-up cycles. Only reset releases them.
- R4: While power-good is low, both lines of every pair settle low within 6 clock cycles, whatever the enables are.
- R5: Pair i runs only when power-good and lock are both high, `oe_n_i[i]` is 0 and register bit i is 1. Running means the true line toggles every clock and the complement line is its inverse. In every other case both lines are low.
- R6: While the PLL lock flag is low, all pairs are blocked with both lines low. This also holds when lock drops after start-up, and the captured straps stay unchanged.
- R7: Until the first power-good, `ref_oe_o` is 0 and `ref_o` is 0. After it, `ref_oe_o` stays 1. `ref_o` toggles every clock while power-good is high and is held at 0 while power-good is low.
- R8: No pair ever has both lines high. The true line rises only after a cycle with the complement line high, and the complement line falls only when the true line rises. Pulses are therefore never shortened.
- R9: The register enable bits reset to all ones. A cycle with `en_wr_i` high loads `en_wdata_i` into them.
- R10: During and right after reset, all pair lines are 0, `ref_oe_o` is 0 and `straps_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output-domain clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pwrgd_i | input | 1 | Power-good; low requests power-down (asynchronous) |
| oe_n_i | input | 8 | Per-pair active-low enable pins (asynchronous) |
| pll_lock_i | input | 1 | PLL lock flag (asynchronous) |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 8 | New value for the enable register |
| sadr_strap_i | input | 1 | Bus-address select strap |
| ss_strap_i | input | 2 | Spread select strap, tri-level encoded |
| dif_t_o | output | 8 | True lines of the differential pairs |
| dif_c_o | output | 8 | Complement lines of the differential pairs |
| ref_o | output | 1 | Reference clock output value |
| ref_oe_o | output | 1 | Reference output drive enable (0 = high impedance) |
| smb_addr_o | output | 7 | Captured 7-bit bus address |
| ss_sel_o | output | 2 | Captured spread code |
| straps_valid_o | output | 1 | Straps have been captured |

## Verification
The hardest state to reach is the one after the first power-good, when new strap values and later power-downs must leave the captured configuration alone and the reference output must switch from undriven to driven low. The bench gets there with repeated reset sequences, each using its own strap setting. In each one it raises power-good, then changes the straps and cycles power-good and lock. Pair gating is swept over all 256 pin patterns against four register patterns, and a monitor samples every cycle to catch shortened pulses.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    SS_OFF     = 2'd0,
    SS_DN_QTR  = 2'd1,
    SS_DN_HALF = 2'd2
  } ss_level_e;

  localparam logic [6:0] BUS_ADDR_BASE = 7'b1101000;

  function automatic ss_level_e decode_ss(input logic [1:0] lvl);
    case (lvl)
      2'b00:   return SS_OFF;
      2'b01:   return SS_DN_QTR;
      default: return SS_DN_HALF;
    endcase
  endfunction

  function automatic logic [6:0] decode_addr(input logic sel);
    return BUS_ADDR_BASE | {5'b00000, sel, 1'b0};
  endfunction
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pm_strap_latch.sv
module pm_strap_latch
  import pm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       pg_i,
  input  logic       sadr_i,
  input  logic [1:0] ss_i,
  output logic [6:0] addr_o,
  output ss_level_e  ss_o,
  output logic       valid_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      ss_o    <= SS_OFF;
    end else if (pg_i && !valid_o) begin
      valid_o <= 1'b1;
      addr_o  <= decode_addr(sadr_i);
      ss_o    <= decode_ss(ss_i);
    end
  end
endmodule

// File: rtl/pm_out_gate.sv
module pm_out_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic phase_i,
  input  logic want_i,
  output logic t_o,
  output logic c_o
);
  logic en_q;

  // Update only on the edge that takes the phase from high to low.
  always_ff @(posedge clk_i) begin
    if (rst_i)        en_q <= 1'b0;
    else if (phase_i) en_q <= want_i;
  end

  assign t_o = phase_i & en_q;
  assign c_o = ~phase_i & en_q;
endmodule

// File: rtl/clkout_pm_ctrl.sv
module clkout_pm_ctrl
  import pm_pkg::*;
#(
  parameter int NUM_PAIRS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 pwrgd_i,
  input  logic [NUM_PAIRS-1:0] oe_n_i,
  input  logic                 pll_lock_i,
  input  logic                 en_wr_i,
  input  logic [NUM_PAIRS-1:0] en_wdata_i,
  input  logic                 sadr_strap_i,
  input  logic [1:0]           ss_strap_i,
  output logic [NUM_PAIRS-1:0] dif_t_o,
  output logic [NUM_PAIRS-1:0] dif_c_o,
  output logic                 ref_o,
  output logic                 ref_oe_o,
  output logic [6:0]           smb_addr_o,
  output logic [1:0]           ss_sel_o,
  output logic                 straps_valid_o
);
  localparam logic [NUM_PAIRS-1:0] ALL_ONES = {NUM_PAIRS{1'b1}};

  logic                 pg_s, lock_s, run_ok;
  logic [NUM_PAIRS-1:0] oe_n_s;
  logic [NUM_PAIRS-1:0] reg_en_q;
  logic                 phase_q;
  logic                 ref_run_q;
  ss_level_e            ss_lvl;

  pm_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(pwrgd_i), .q_o(pg_s));

  pm_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(pll_lock_i), .q_o(lock_s));

  pm_sync #(.W(NUM_PAIRS), .STAGES(SYNC_STAGES), .RST_VAL(ALL_ONES)) u_oe_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(oe_n_i), .q_o(oe_n_s));

  pm_strap_latch u_straps (
    .clk_i(clk_i), .rst_i(rst_i), .pg_i(pg_s),
    .sadr_i(sadr_strap_i), .ss_i(ss_strap_i),
    .addr_o(smb_addr_o), .ss_o(ss_lvl), .valid_o(straps_valid_o));

  assign ss_sel_o = ss_lvl;

  always_ff @(posedge clk_i) begin
    if (rst_i) phase_q <= 1'b0;
    else       phase_q <= ~phase_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        reg_en_q <= ALL_ONES;
    else if (en_wr_i) reg_en_q <= en_wdata_i;
  end

  assign run_ok = pg_s & lock_s;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    pm_out_gate u_gate (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .phase_i(phase_q),
      .want_i (run_ok & ~oe_n_s[g] & reg_en_q[g]),
      .t_o    (dif_t_o[g]),
      .c_o    (dif_c_o[g]));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        ref_run_q <= 1'b0;
    else if (phase_q) ref_run_q <= pg_s;
  end

  assign ref_o    = phase_q & ref_run_q;
  assign ref_oe_o = straps_valid_o;
endmodule

// File: rtl/pm_ctrl_chk.sv
module pm_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         pg_s,
  input logic         lock_s,
  input logic [N-1:0] dif_t_o,
  input logic [N-1:0] dif_c_o,
  input logic         ref_o,
  input logic         ref_oe_o,
  input logic [6:0]   smb_addr_o,
  input logic [1:0]   ss_sel_o,
  input logic         straps_valid_o
);
  p_pd_low_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pg_s && !$past(pg_s) && !$past(pg_s, 2)) |-> ((dif_t_o | dif_c_o) == '0));

  p_lock_block_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!lock_s && !$past(lock_s) && !$past(lock_s, 2)) |-> ((dif_t_o | dif_c_o) == '0));

  p_straps_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(straps_valid_o) |-> ($stable(smb_addr_o) && $stable(ss_sel_o) && straps_valid_o));

  p_ref_hiz_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !straps_valid_o |-> (!ref_oe_o && !ref_o));

  p_ref_pd_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (straps_valid_o && !pg_s && !$past(pg_s) && !$past(pg_s, 2)) |-> (ref_oe_o && !ref_o));

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_true_rise_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(dif_t_o[i]) |-> $past(dif_c_o[i]));

    p_comp_fall_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(dif_c_o[i]) |-> dif_t_o[i]);
  end
endmodule

bind clkout_pm_ctrl pm_ctrl_chk #(.N(NUM_PAIRS)) u_pm_chk (
  .clk_i(clk_i), .rst_i(rst_i), .pg_s(pg_s), .lock_s(lock_s),
  .dif_t_o(dif_t_o), .dif_c_o(dif_c_o), .ref_o(ref_o), .ref_oe_o(ref_oe_o),
  .smb_addr_o(smb_addr_o), .ss_sel_o(ss_sel_o), .straps_valid_o(straps_valid_o));

// File: tb/clkout_pm_ctrl_bench.sv
module clkout_pm_ctrl_bench;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwrgd = 1'b0;
  logic [NP-1:0] oe_n = '1;
  logic          lock = 1'b0;
  logic          en_wr = 1'b0;
  logic [NP-1:0] en_wdata = '0;
  logic          sadr = 1'b0;
  logic [1:0]    ss = 2'b00;
  logic [NP-1:0] dif_t, dif_c;
  logic          ref_o, ref_oe, valid;
  logic [6:0]    addr;
  logic [1:0]    ss_sel;

  int checks = 0;
  int fails = 0;
  int glitches = 0;
  bit done = 1'b0;
  logic [NP-1:0] prev_t = '0, prev_c = '0;

  always #2 clk = ~clk;

  clkout_pm_ctrl #(.NUM_PAIRS(NP)) u_clkout_pm_ctrl (
    .clk_i(clk), .rst_i(rst), .pwrgd_i(pwrgd), .oe_n_i(oe_n),
    .pll_lock_i(lock), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .sadr_strap_i(sadr), .ss_strap_i(ss),
    .dif_t_o(dif_t), .dif_c_o(dif_c), .ref_o(ref_o), .ref_oe_o(ref_oe),
    .smb_addr_o(addr), .ss_sel_o(ss_sel), .straps_valid_o(valid));

  // R8 monitor: no overlap, no true rise out of both-low, no complement drop into both-low
  always @(negedge clk) begin
    if (!rst) begin
      if ((dif_t & dif_c) != '0) glitches++;
      for (int i = 0; i < NP; i++) begin
        if (dif_t[i] && !prev_t[i] && !prev_c[i]) glitches++;
        if (!dif_c[i] && prev_c[i] && !dif_t[i]) glitches++;
      end
    end
    prev_t = dif_t;
    prev_c = dif_c;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pwrgd = 1'b0; lock = 1'b0; en_wr = 1'b0;
    settle(4);
    rst = 1'b0;
  endtask

  task automatic write_en(input logic [NP-1:0] v);
    en_wr = 1'b1; en_wdata = v;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  // Two consecutive samples decide running vs held low per pair
  task automatic check_pairs(input string req, input logic [NP-1:0] exp_run);
    logic [NP-1:0] t1, c1, t2, c2;
    t1 = dif_t; c1 = dif_c;
    @(negedge clk);
    t2 = dif_t; c2 = dif_c;
    for (int i = 0; i < NP; i++) begin
      bit run_obs, off_obs;
      run_obs = (t1[i] != t2[i]) && (c1[i] == !t1[i]) && (c2[i] == !t2[i]);
      off_obs = !t1[i] && !c1[i] && !t2[i] && !c2[i];
      chk(exp_run[i] ? run_obs : off_obs, req, $sformatf("pair %0d running", i),
          run_obs ? 1 : 0, exp_run[i] ? 1 : 0);
    end
  endtask

  task automatic check_ref(input string req, input bit exp_oe, input bit exp_run);
    logic r1, r2;
    r1 = ref_o;
    chk(ref_oe == exp_oe, req, "ref_oe", ref_oe, exp_oe);
    @(negedge clk);
    r2 = ref_o;
    if (exp_run) chk(r1 != r2, req, "ref toggling", r2, !r1);
    else         chk(!r1 && !r2, req, "ref held low", r1 | r2, 0);
  endtask

  task automatic check_straps(input string req, input logic s_adr, input logic [1:0] s_ss);
    logic [6:0] ea;
    int es;
    ea = 7'b1101000 | (s_adr ? 7'b0000010 : 7'b0000000);
    es = (s_ss == 2'b00) ? 0 : (s_ss == 2'b01) ? 1 : 2;
    chk(valid == 1'b1, req, "straps_valid", valid, 1);
    chk(addr == ea, req, "bus address", addr, ea);
    chk(ss_sel == es[1:0], req, "spread code", ss_sel, es);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // Scenario with address strap 1 and mid spread
    sadr = 1'b1; ss = 2'b01; oe_n = '0;
    do_reset();
    settle(1);
    // R10 reset state
    chk((dif_t | dif_c) == '0, "R10", "pairs after reset", dif_t | dif_c, 0);
    chk(ref_oe == 1'b0, "R10", "ref_oe after reset", ref_oe, 0);
    chk(valid == 1'b0, "R10", "straps_valid after reset", valid, 0);
    // R7 ref not driven before first power-good
    lock = 1'b1;
    settle(8);
    check_ref("R7", 1'b0, 1'b0);
    check_pairs("R4", '0);
    // First power-good: R1, R2, and R9 (no writes, all pins enabled)
    pwrgd = 1'b1;
    settle(8);
    check_straps("R1", 1'b1, 2'b01);
    check_straps("R2", 1'b1, 2'b01);
    check_pairs("R9", '1);
    check_ref("R7", 1'b1, 1'b1);
    // R3 strap changes ignored
    sadr = 1'b0; ss = 2'b10;
    settle(8);
    check_straps("R3", 1'b1, 2'b01);
    // Power-down: R4 pairs low, R7 ref driven low
    pwrgd = 1'b0;
    settle(8);
    check_pairs("R4", '0);
    check_ref("R7", 1'b1, 1'b0);
    check_straps("R3", 1'b1, 2'b01);
    pwrgd = 1'b1;
    settle(8);
    check_straps("R3", 1'b1, 2'b01);
    check_pairs("R5", '1);
    // R6 lock loss after start-up
    lock = 1'b0;
    settle(8);
    check_pairs("R6", '0);
    check_straps("R6", 1'b1, 2'b01);
    check_ref("R7", 1'b1, 1'b1);
    lock = 1'b1;
    settle(8);
    check_pairs("R6", '1);

    // R5 sweep: every pin pattern against four register patterns
    for (int ov = 0; ov < 256; ov++) begin
      for (int rp = 0; rp < 4; rp++) begin
        logic [NP-1:0] rv;
        case (rp)
          0: rv = 8'hFF;
          1: rv = 8'h00;
          2: rv = 8'hA5;
          default: rv = ov[7:0] ^ 8'h3C;
        endcase
        write_en(rv);
        oe_n = ov[7:0];
        settle(8);
        check_pairs("R5", ~ov[7:0] & rv);
      end
    end

    // R9 register write takes effect
    oe_n = '0;
    write_en(8'h0F);
    settle(8);
    check_pairs("R9", 8'h0F);

    // R4 and R6 with several enable patterns
    for (int k = 0; k < 4; k++) begin
      logic [NP-1:0] pat;
      pat = 8'h1 << (k * 2);
      write_en('1);
      oe_n = ~pat;
      pwrgd = 1'b0;
      settle(8);
      check_pairs("R4", '0);
      pwrgd = 1'b1; lock = 1'b0;
      settle(8);
      check_pairs("R6", '0);
      lock = 1'b1;
      settle(8);
      check_pairs("R5", pat);
    end

    // Strap capture for the other settings, one reset each
    for (int sc = 0; sc < 4; sc++) begin
      logic         s_a;
      logic [1:0]   s_s;
      s_a = sc[0];
      s_s = sc[1:0] ^ 2'b10;
      sadr = s_a; ss = s_s; oe_n = '0;
      do_reset();
      settle(8);
      check_ref("R7", 1'b0, 1'b0);
      lock = 1'b1; pwrgd = 1'b1;
      settle(8);
      check_straps("R1", s_a, s_s);
      check_straps("R2", s_a, s_s);
      sadr = ~s_a; ss = ~s_s;
      pwrgd = 1'b0;
      settle(8);
      check_ref("R7", 1'b1, 1'b0);
      pwrgd = 1'b1;
      settle(8);
      check_straps("R3", s_a, s_s);
    end

    chk(glitches == 0, "R8", "shortened or overlapping pulses", glitches, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule